// File: doc/BRIEF.md
# Radix-2² Delay-Feedback Butterfly Stage Pair

This block is the front stage pair of a pipelined radix-2² FFT built on single-path delay feedback. It accepts one complex sample per accepted clock, in natural order, and forms two cascaded radix-2 butterflies. The first butterfly pairs samples half a frame apart through a feedback store of N/2 entries. The second pairs samples a quarter frame apart through a store of N/4 entries, and rotates selected incoming samples by -j. A single frame counter, advanced by each accepted sample, sets both butterfly phases, the rotation and the addresses of both feedback stores.

The output stream is the partially transformed frame. The general twiddle multiplier is expected to follow it, and bit-reversal reordering is expected further down the chain. Frames run back to back with no pause. A low `in_valid` freezes the whole pipeline, so gaps in the input never change results. Each butterfly adds one guard bit, so the output is two bits wider than the input.

Top module: `r22_sdf_pair`

## Requirements
- R1: During and straight after a synchronous reset (`rst` high), `out_valid` is 0 and `out_re`/`out_im` are 0; the frame counter restarts at sample 0.
- R2: `out_valid` is high in a cycle only if `in_valid` was high in the previous cycle. A cycle with `in_valid` low advances nothing, so inserting idle cycles changes no output value or order.
- R3: While `out_valid` is low, `out_re` and `out_im` keep the last value they carried.
- R4: The first `out_valid` after reset appears in the cycle after the input sample with index 3N/4 (counting from 0) has been accepted. It carries output index 0 of frame 0, and every later accepted sample yields exactly one output.
- R5: Let a[n] = x[n] + x[n+N/2] and b[n] = x[n] − x[n+N/2], for n in 0..N/2−1, within one frame x. Output positions 0..N/4−1 of a frame are a[n] + a[n+N/4], with n ascending.
- R6: Output positions N/4..N/2−1 are a[n] − a[n+N/4], with n ascending.
- R7: Output positions N/2..3N/4−1 are b[n] + R(b[n+N/4]), with n ascending. Here R is the −j rotation, mapping (re, im) to (im, −re).
- R8: Output positions 3N/4..N−1 are b[n] − R(b[n+N/4]), with n ascending.
- R9: Outputs are W+2 bits signed and exact, with no wrap, for any W-bit signed inputs. This includes full-scale patterns whose intermediate results reach ±2^W.
- R10: Consecutive frames need no gap. Output position p of frame f is emitted when input sample f·N + p + 3N/4 is accepted, so a stream of S samples yields S − 3N/4 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present this cycle |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| out_valid | output | 1 | Output sample is present this cycle |
| out_re | output | W+2 | Output real part, signed |
| out_im | output | W+2 | Output imaginary part, signed |

## Verification
A counter that is off by one sample, or a select bit taken from the wrong counter position, moves the quarter boundaries. The first output frame then shows sums where differences belong, or a rotation applied in the wrong quarter, within N outputs of the first `out_valid`. A corrupted feedback entry shows up as a wrong value exactly N/2 or N/4 accepted samples after it was written. A priming error shows as a wrong count of inputs before the first `out_valid`. Full-scale half-frame patterns expose a missing guard bit as a sign flip in the very frame that carries them.

// File: rtl/r22_pkg.sv
package r22_pkg;

    // Phase of one butterfly: pass into the store, or combine with it
    typedef enum logic {
        BF_PASS    = 1'b0,
        BF_COMBINE = 1'b1
    } bf_phase_e;

endpackage

// File: rtl/r22_fb_ram.sv
// Feedback store: asynchronous read of the old entry, write at the clock edge
module r22_fb_ram #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 13,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic signed [WIDTH-1:0] wr_re,
    input  logic signed [WIDTH-1:0] wr_im,
    output logic signed [WIDTH-1:0] rd_re,
    output logic signed [WIDTH-1:0] rd_im
);

    logic [2*WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= {wr_re, wr_im};
        end
    end

    always_comb begin
        rd_re = mem_q[addr][2*WIDTH-1:WIDTH];
        rd_im = mem_q[addr][WIDTH-1:0];
    end

endmodule

// File: rtl/r22_bfly.sv
// One delay-feedback butterfly with an optional -j rotation of the incoming sample
module r22_bfly
    import r22_pkg::*;
#(
    parameter int WI = 12,
    localparam int WO = WI + 1
) (
    input  logic                 sel,
    input  logic                 rot,
    input  logic signed [WI-1:0] x_re,
    input  logic signed [WI-1:0] x_im,
    input  logic signed [WO-1:0] d_re,
    input  logic signed [WO-1:0] d_im,
    output logic signed [WO-1:0] y_re,
    output logic signed [WO-1:0] y_im,
    output logic signed [WO-1:0] f_re,
    output logic signed [WO-1:0] f_im
);

    logic signed [WO-1:0] e_re, e_im;
    logic signed [WO-1:0] r_re, r_im;
    logic signed [WO-1:0] n_re, n_im;

    always_comb begin
        e_re = {x_re[WI-1], x_re};
        e_im = {x_im[WI-1], x_im};
        if (rot) begin
            r_re = e_im;
            r_im = -e_re;
        end else begin
            r_re = e_re;
            r_im = e_im;
        end
        n_re = -r_re;
        n_im = -r_im;
        if (bf_phase_e'(sel) == BF_COMBINE) begin
            y_re = d_re + r_re;
            y_im = d_im + r_im;
            f_re = d_re + n_re;
            f_im = d_im + n_im;
        end else begin
            y_re = d_re;
            y_im = d_im;
            f_re = r_re;
            f_im = r_im;
        end
    end

endmodule

// File: rtl/r22_sdf_pair.sv
module r22_sdf_pair #(
    parameter int N = 16,
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic                out_valid,
    output logic signed [W+1:0] out_re,
    output logic signed [W+1:0] out_im
);

    localparam int CW = $clog2(N);
    localparam int H  = N / 2;
    localparam int Q  = N / 4;
    localparam int HA = CW - 1;
    localparam int QA = CW - 2;
    localparam int W1 = W + 1;
    localparam int WO = W + 2;
    localparam logic [CW-1:0] PRIME_LAST = CW'(3 * Q - 1);
    localparam logic [CW-1:0] PRIME_NEXT = CW'(3 * Q);

    typedef struct packed {
        logic [CW-1:0]        cnt;
        logic                 primed;
        logic                 ovalid;
        logic signed [WO-1:0] ore;
        logic signed [WO-1:0] oim;
    } state_t;

    state_t st_d, st_q;

    logic sel1, sel2, rot2;
    logic signed [W1-1:0] d1_re, d1_im, y1_re, y1_im, f1_re, f1_im;
    logic signed [WO-1:0] d2_re, d2_im, y2_re, y2_im, f2_re, f2_im;

    // Counter MSB: second half of the frame combines in the first butterfly.
    // Second butterfly sees its stream offset by N/2, so its quarter bit is the
    // next counter bit and its difference half is where the MSB is 0.
    assign sel1 = st_q.cnt[CW-1];
    assign sel2 = st_q.cnt[CW-2];
    assign rot2 = st_q.cnt[CW-2] & ~st_q.cnt[CW-1];

    r22_fb_ram #(.DEPTH(H), .WIDTH(W1)) u_ram1 (
        .clk  (clk),
        .we   (in_valid),
        .addr (st_q.cnt[HA-1:0]),
        .wr_re(f1_re),
        .wr_im(f1_im),
        .rd_re(d1_re),
        .rd_im(d1_im)
    );

    r22_bfly #(.WI(W)) u_bf1 (
        .sel (sel1),
        .rot (1'b0),
        .x_re(in_re),
        .x_im(in_im),
        .d_re(d1_re),
        .d_im(d1_im),
        .y_re(y1_re),
        .y_im(y1_im),
        .f_re(f1_re),
        .f_im(f1_im)
    );

    r22_fb_ram #(.DEPTH(Q), .WIDTH(WO)) u_ram2 (
        .clk  (clk),
        .we   (in_valid),
        .addr (st_q.cnt[QA-1:0]),
        .wr_re(f2_re),
        .wr_im(f2_im),
        .rd_re(d2_re),
        .rd_im(d2_im)
    );

    r22_bfly #(.WI(W1)) u_bf2 (
        .sel (sel2),
        .rot (rot2),
        .x_re(y1_re),
        .x_im(y1_im),
        .d_re(d2_re),
        .d_im(d2_im),
        .y_re(y2_re),
        .y_im(y2_im),
        .f_re(f2_re),
        .f_im(f2_im)
    );

    always_comb begin
        st_d = st_q;
        st_d.ovalid = in_valid & st_q.primed;
        if (in_valid) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == PRIME_LAST) begin
                st_d.primed = 1'b1;
            end
            if (st_q.primed) begin
                st_d.ore = y2_re;
                st_d.oim = y2_im;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ovalid;
    assign out_re    = st_q.ore;
    assign out_im    = st_q.oim;

    AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));  // R2

    AST_IDLE_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));  // R3

    AST_QUIET_UNTIL_PRIMED: assert property (@(posedge clk) disable iff (rst)
        !st_q.primed |=> !out_valid);  // R4

    AST_PRIME_POINT: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.primed) |-> (st_q.cnt == PRIME_NEXT));  // R4

endmodule

// File: tb/sim_r22_sdf_pair.sv
`timescale 1ns/1ps
module sim_r22_sdf_pair;

    localparam int W     = 12;
    localparam int TOTAL = 1024;
    localparam int NA    = 16;
    localparam int NB    = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst;
    logic                in_valid;
    logic signed [W-1:0] in_re, in_im;
    logic                ov0, ov1;
    logic signed [W+1:0] or0, oi0, or1, oi1;

    r22_sdf_pair #(.N(NA), .W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(ov0), .out_re(or0), .out_im(oi0)
    );

    r22_sdf_pair #(.N(NB), .W(W)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(ov1), .out_re(or1), .out_im(oi1)
    );

    int hist_re [TOTAL];
    int hist_im [TOTAL];
    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int m0 = 0, m1 = 0;
    int first0 = -1, first1 = -1;
    int p0r = 0, p0i = 0, p1r = 0, p1i = 0;

    function automatic void stim(input int idx, output int sr, output int si);
        logic [31:0] b;
        b = idx;
        if (idx < 64) begin
            sr = (idx == 0) ? 1000 : (idx == 37) ? -450 : 0;
            si = (idx == 0) ? -300 : (idx == 37) ? 800 : 0;
        end else if (idx < 128) begin
            sr = 500;
            si = -700;
        end else if (idx < 192) begin
            sr = b[3] ? -2048 : 2047;
            si = b[5] ? 2047 : -2048;
        end else if (idx < 256) begin
            sr = b[5] ? -2048 : 2047;
            si = b[3] ? 2047 : -2048;
        end else begin
            sr = int'($urandom_range(4095)) - 2048;
            si = int'($urandom_range(4095)) - 2048;
        end
    endfunction

    // Expected output m of an nn-point stage pair, straight from R5..R8
    function automatic void ref_out(input int nn, input int m, output int er, output int ei);
        int q, h, f0, p, n, qu, ar, ai, cr, ci, tr, ti;
        q  = nn / 4;
        h  = nn / 2;
        f0 = (m / nn) * nn;
        p  = m % nn;
        n  = p % q;
        qu = p / q;
        if (qu < 2) begin
            ar = hist_re[f0+n] + hist_re[f0+n+h];
            ai = hist_im[f0+n] + hist_im[f0+n+h];
            cr = hist_re[f0+n+q] + hist_re[f0+n+q+h];
            ci = hist_im[f0+n+q] + hist_im[f0+n+q+h];
        end else begin
            ar = hist_re[f0+n] - hist_re[f0+n+h];
            ai = hist_im[f0+n] - hist_im[f0+n+h];
            tr = hist_re[f0+n+q] - hist_re[f0+n+q+h];
            ti = hist_im[f0+n+q] - hist_im[f0+n+q+h];
            cr = ti;
            ci = -tr;
        end
        if (qu % 2 == 0) begin
            er = ar + cr;
            ei = ai + ci;
        end else begin
            er = ar - cr;
            ei = ai - ci;
        end
    endfunction

    function automatic string tag_of(input int nn, input int m);
        int f0;
        f0 = (m / nn) * nn;
        if (f0 >= 128 && f0 < 256) return "R9";
        case ((m % nn) / (nn / 4))
            0:       return "R5";
            1:       return "R6";
            2:       return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic mon(input int nn, input logic ov, input int ar, input int ai,
                       input logic was_valid, inout int m, inout int first,
                       inout int pr, inout int pi);
        int er, ei;
        if (ov) begin
            checks++;
            if (!was_valid) begin
                fails++;
                $display("FAIL R2 N=%0d out_valid without input: actual 1 expected 0", nn);
            end
            if (first < 0) first = k;
            ref_out(nn, m, er, ei);
            checks++;
            if (ar != er || ai != ei) begin
                fails++;
                $display("FAIL %s N=%0d out %0d: actual (%0d,%0d) expected (%0d,%0d)",
                         tag_of(nn, m), nn, m, ar, ai, er, ei);
            end
            m++;
            pr = ar;
            pi = ai;
        end else begin
            checks++;
            if (ar != pr || ai != pi) begin
                fails++;
                $display("FAIL R3 N=%0d held output: actual (%0d,%0d) expected (%0d,%0d)",
                         nn, ar, ai, pr, pi);
            end
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic expect_eq(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed;
        int sr, si;
        logic go;
        seed = $urandom(32'd11);
        rst = 1'b1;
        in_valid = 1'b0;
        in_re = '0;
        in_im = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_eq("R1 u0 out_valid after reset", int'(ov0), 0);
        expect_eq("R1 u0 out_re after reset", int'(or0), 0);
        expect_eq("R1 u1 out_valid after reset", int'(ov1), 0);
        expect_eq("R1 u1 out_im after reset", int'(oi1), 0);
        // a few idle cycles before the first sample
        repeat (3) begin
            @(negedge clk);
            mon(NA, ov0, int'(or0), int'(oi0), in_valid, m0, first0, p0r, p0i);
            mon(NB, ov1, int'(or1), int'(oi1), in_valid, m1, first1, p1r, p1i);
        end
        while (k < TOTAL) begin
            go = (k < 256) || ($urandom_range(3) != 0);
            if (go) begin
                stim(k, sr, si);
                hist_re[k] = sr;
                hist_im[k] = si;
                in_re = W'(sr);
                in_im = W'(si);
            end
            in_valid = go;
            @(negedge clk);
            if (go) k++;
            mon(NA, ov0, int'(or0), int'(oi0), in_valid, m0, first0, p0r, p0i);
            mon(NB, ov1, int'(or1), int'(oi1), in_valid, m1, first1, p1r, p1i);
        end
        in_valid = 1'b0;
        repeat (6) begin
            @(negedge clk);
            mon(NA, ov0, int'(or0), int'(oi0), in_valid, m0, first0, p0r, p0i);
            mon(NB, ov1, int'(or1), int'(oi1), in_valid, m1, first1, p1r, p1i);
        end
        expect_eq("R4 u0 inputs accepted at first output", first0, 3 * NA / 4 + 1);
        expect_eq("R4 u1 inputs accepted at first output", first1, 3 * NB / 4 + 1);
        expect_eq("R10 u0 output count", m0, TOTAL - 3 * NA / 4);
        expect_eq("R10 u1 output count", m1, TOTAL - 3 * NB / 4);
        summary();
        $finish;
    end

endmodule